// File: doc/BRIEF.md
# Hypervisor Trap-Entry Status Recorder

This block keeps the privilege-stack status fields of a core that implements a hypervisor extension and updates them when a trap is taken or when a trap return executes. The pipeline supplies the privilege level and virtualization bit that are really executing. It also raises a one-cycle trap strobe with a target select, which picks machine level or hypervisor-supervisor level. Three qualifiers travel with the strobe. The first says whether the trap is a memory fault. The second says whether the faulting access came from a hypervisor guest load or store (including the execute-permission load form). The third says whether the access was made by machine code under the modified-privilege setting.

The recorded previous-mode fields always hold the mode that was actually running. They never hold the "as-though" mode that a guest load/store or a modified-privilege access used for its translation. The guest-address flag is therefore computed on its own and can differ from the saved virtualization bit. A return strobe rebuilds the resumed mode from the saved fields alone. The block also drives the current mode that results from each event.

Top module: `trap_status_recorder`

## Requirements
- R1: While rst_n is low, and after it is released, the fields are: mpp_q=0, mpv_q=0, spp_q=0, spv_q=0, spvp_q=0, gva_q=0, mode_priv=3 (machine), mode_virt=0.
- R2: Privilege codes are user=0, supervisor=1 and machine=3. On a trap to HS level (trap_vld=1, trap_to_m=0), spp_q takes 1 exactly when cur_priv is supervisor, and spv_q takes cur_virt. The new mode is supervisor with virtualization 0. hv_access and mprv_access do not change these fields.
- R3: On a trap to HS level from cur_virt=1, spvp_q takes 1 if cur_priv is supervisor and 0 otherwise. On a trap to HS level from cur_virt=0, spvp_q keeps its value.
- R4: On a trap to M level, mpp_q takes cur_priv (which is 3 for a machine access under modified privilege, whatever mpp_q held before) and mpv_q takes cur_virt. The new mode is machine with virtualization 0. spp_q, spv_q and spvp_q do not change.
- R5: gva_q is written on every trap. With mem_fault=1 it is 1 if cur_virt=1, or hv_access=1, or (mprv_access=1 and mpv_q=1 before the trap), and 0 otherwise. An ordinary fault therefore copies the saved virtualization bit. A guest load/store fault from cur_virt=0 gives spv_q=0 and gva_q=1. With mem_fault=0 the flag is written 0.
- R6: In a cycle with neither trap_vld nor ret_vld, every output holds its value.
- R7: A supervisor return (ret_vld=1, ret_to_m=0) sets mode_priv to supervisor if spp_q=1 and to user otherwise, and sets mode_virt to spv_q. It then clears spp_q and spv_q.
- R8: A machine return (ret_vld=1, ret_to_m=1) sets mode_priv to mpp_q, and sets mode_virt to mpv_q unless mpp_q is machine. It then clears mpp_q to user and mpv_q to 0.
- R9: When trap_vld and ret_vld are both high in one cycle, only the trap takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_vld | input | 1 | One-cycle trap strobe |
| trap_to_m | input | 1 | Trap target: 1 = machine, 0 = HS |
| cur_priv | input | 2 | Privilege level actually executing |
| cur_virt | input | 1 | Virtualization bit actually in force |
| mem_fault | input | 1 | Trap is a memory-access fault |
| hv_access | input | 1 | Faulting access is a hypervisor guest load/store |
| mprv_access | input | 1 | Faulting access used modified privilege |
| ret_vld | input | 1 | Trap-return strobe |
| ret_to_m | input | 1 | Return kind: 1 = machine, 0 = supervisor |
| mpp_q | output | 2 | Machine previous privilege |
| mpv_q | output | 1 | Machine previous virtualization |
| spp_q | output | 1 | Supervisor previous privilege |
| spv_q | output | 1 | Supervisor previous virtualization |
| spvp_q | output | 1 | Saved guest privilege of last guest trap |
| gva_q | output | 1 | Guest virtual address flag |
| mode_priv | output | 2 | Current privilege after the last event |
| mode_virt | output | 1 | Current virtualization after the last event |

## Verification
Every output is a register loaded on the rising edge that samples the strobe. Each result of a trap or return is therefore visible exactly one clock after the strobe is presented and stays put until the next strobe. The bench drives each strobe on a falling edge. It compares the complete field set at the following falling edge, half a period after the only register stage. Idle stretches are compared after several cycles, which shows that nothing drifts between events.

// File: rtl/trap_rec_pkg.sv
package trap_rec_pkg;
  localparam int PRIV_W = 2;

  typedef enum logic [PRIV_W-1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

  typedef struct packed {
    logic spp;
    logic spv;
    logic spvp;
  } hs_fields_t;

  typedef struct packed {
    priv_e mpp;
    logic  mpv;
  } m_fields_t;
endpackage

// File: rtl/trap_rec_hs_next.sv
module trap_rec_hs_next
  import trap_rec_pkg::*;
(
  input  logic       trap_hs,
  input  logic       sret,
  input  priv_e      cur_priv,
  input  logic       cur_virt,
  input  hs_fields_t hs_q,
  output logic       hs_en,
  output hs_fields_t hs_d,
  output priv_e      res_priv,
  output logic       res_virt
);
  always_comb begin
    hs_en = trap_hs | sret;
    hs_d  = hs_q;
    if (trap_hs) begin
      hs_d.spp = (cur_priv == PRIV_S);
      hs_d.spv = cur_virt;
      if (cur_virt) begin
        hs_d.spvp = (cur_priv == PRIV_S);
      end
    end else if (sret) begin
      hs_d.spp = 1'b0;
      hs_d.spv = 1'b0;
    end
  end

  always_comb begin
    res_priv = hs_q.spp ? PRIV_S : PRIV_U;
    res_virt = hs_q.spv;
  end
endmodule

// File: rtl/trap_rec_m_next.sv
module trap_rec_m_next
  import trap_rec_pkg::*;
(
  input  logic      trap_m,
  input  logic      mret,
  input  priv_e     cur_priv,
  input  logic      cur_virt,
  input  m_fields_t m_q,
  output logic      m_en,
  output m_fields_t m_d,
  output priv_e     res_priv,
  output logic      res_virt
);
  always_comb begin
    m_en = trap_m | mret;
    m_d  = m_q;
    if (trap_m) begin
      m_d.mpp = cur_priv;
      m_d.mpv = cur_virt;
    end else if (mret) begin
      m_d.mpp = PRIV_U;
      m_d.mpv = 1'b0;
    end
  end

  always_comb begin
    res_priv = m_q.mpp;
    res_virt = (m_q.mpp != PRIV_M) & m_q.mpv;
  end
endmodule

// File: rtl/trap_rec_gva.sv
module trap_rec_gva (
  input  logic trap_vld,
  input  logic mem_fault,
  input  logic cur_virt,
  input  logic hv_access,
  input  logic mprv_access,
  input  logic mpv_q,
  output logic gva_en,
  output logic gva_d
);
  logic guest_access;

  always_comb begin
    guest_access = cur_virt | hv_access | (mprv_access & mpv_q);
    gva_en       = trap_vld;
    gva_d        = mem_fault & guest_access;
  end
endmodule

// File: rtl/trap_status_recorder.sv
module trap_status_recorder
  import trap_rec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trap_vld,
  input  logic       trap_to_m,
  input  logic [1:0] cur_priv,
  input  logic       cur_virt,
  input  logic       mem_fault,
  input  logic       hv_access,
  input  logic       mprv_access,
  input  logic       ret_vld,
  input  logic       ret_to_m,
  output logic [1:0] mpp_q,
  output logic       mpv_q,
  output logic       spp_q,
  output logic       spv_q,
  output logic       spvp_q,
  output logic       gva_q,
  output logic [1:0] mode_priv,
  output logic       mode_virt
);
  priv_e      cur_priv_e;
  logic       trap_hs, trap_m, ret_ok, sret, mret;

  hs_fields_t hs_q, hs_d;
  logic       hs_en;
  priv_e      hs_res_priv;
  logic       hs_res_virt;

  m_fields_t  m_q, m_d;
  logic       m_en;
  priv_e      m_res_priv;
  logic       m_res_virt;

  logic       gva_r, gva_d, gva_en;

  priv_e      mode_priv_r, mode_priv_d;
  logic       mode_virt_r, mode_virt_d, mode_en;

  // event decode: a trap always wins over a return in the same cycle
  always_comb begin
    cur_priv_e = priv_e'(cur_priv);
    trap_hs    = trap_vld & ~trap_to_m;
    trap_m     = trap_vld & trap_to_m;
    ret_ok     = ret_vld & ~trap_vld;
    sret       = ret_ok & ~ret_to_m;
    mret       = ret_ok & ret_to_m;
  end

  trap_rec_hs_next u_hs (
    .trap_hs  (trap_hs),
    .sret     (sret),
    .cur_priv (cur_priv_e),
    .cur_virt (cur_virt),
    .hs_q     (hs_q),
    .hs_en    (hs_en),
    .hs_d     (hs_d),
    .res_priv (hs_res_priv),
    .res_virt (hs_res_virt)
  );

  trap_rec_m_next u_m (
    .trap_m   (trap_m),
    .mret     (mret),
    .cur_priv (cur_priv_e),
    .cur_virt (cur_virt),
    .m_q      (m_q),
    .m_en     (m_en),
    .m_d      (m_d),
    .res_priv (m_res_priv),
    .res_virt (m_res_virt)
  );

  trap_rec_gva u_gva (
    .trap_vld    (trap_vld),
    .mem_fault   (mem_fault),
    .cur_virt    (cur_virt),
    .hv_access   (hv_access),
    .mprv_access (mprv_access),
    .mpv_q       (m_q.mpv),
    .gva_en      (gva_en),
    .gva_d       (gva_d)
  );

  // next current mode
  always_comb begin
    mode_en     = trap_vld | ret_ok;
    mode_priv_d = mode_priv_r;
    mode_virt_d = mode_virt_r;
    if (trap_hs) begin
      mode_priv_d = PRIV_S;
      mode_virt_d = 1'b0;
    end else if (trap_m) begin
      mode_priv_d = PRIV_M;
      mode_virt_d = 1'b0;
    end else if (sret) begin
      mode_priv_d = hs_res_priv;
      mode_virt_d = hs_res_virt;
    end else if (mret) begin
      mode_priv_d = m_res_priv;
      mode_virt_d = m_res_virt;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= '0;
    end else if (hs_en) begin
      hs_q <= hs_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '{mpp: PRIV_U, mpv: 1'b0};
    end else if (m_en) begin
      m_q <= m_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gva_r <= 1'b0;
    end else if (gva_en) begin
      gva_r <= gva_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_priv_r <= PRIV_M;
      mode_virt_r <= 1'b0;
    end else if (mode_en) begin
      mode_priv_r <= mode_priv_d;
      mode_virt_r <= mode_virt_d;
    end
  end

  assign mpp_q     = m_q.mpp;
  assign mpv_q     = m_q.mpv;
  assign spp_q     = hs_q.spp;
  assign spv_q     = hs_q.spv;
  assign spvp_q    = hs_q.spvp;
  assign gva_q     = gva_r;
  assign mode_priv = mode_priv_r;
  assign mode_virt = mode_virt_r;
endmodule

// File: rtl/trap_rec_chk.sv
module trap_rec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trap_vld,
  input logic       trap_to_m,
  input logic [1:0] cur_priv,
  input logic       cur_virt,
  input logic       mem_fault,
  input logic       hv_access,
  input logic       ret_vld,
  input logic       ret_to_m,
  input logic [1:0] mpp_q,
  input logic       mpv_q,
  input logic       spp_q,
  input logic       spv_q,
  input logic       spvp_q,
  input logic       gva_q,
  input logic [1:0] mode_priv,
  input logic       mode_virt
);
  assert_hs_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_vld && !trap_to_m) |=>
      (spv_q == $past(cur_virt)) && (spp_q == ($past(cur_priv) == 2'd1))
      && (mode_priv == 2'd1) && !mode_virt);

  assert_spvp_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_vld && !trap_to_m && !cur_virt) |=> $stable(spvp_q));

  assert_m_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_vld && trap_to_m) |=>
      (mpp_q == $past(cur_priv)) && (mpv_q == $past(cur_virt))
      && (mode_priv == 2'd3) && !mode_virt && $stable({spp_q, spv_q, spvp_q}));

  assert_gva_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_vld && !trap_to_m && mem_fault && hv_access && !cur_virt) |=>
      (gva_q && !spv_q));

  assert_gva_nofault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_vld && !mem_fault) |=> !gva_q);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_vld && !ret_vld) |=>
      $stable({mpp_q, mpv_q, spp_q, spv_q, spvp_q, gva_q, mode_priv, mode_virt}));

  assert_sret_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && !ret_to_m && !trap_vld) |=>
      (mode_priv == {1'b0, $past(spp_q)}) && (mode_virt == $past(spv_q))
      && !spp_q && !spv_q);

  assert_mret_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && ret_to_m && !trap_vld) |=>
      (mode_priv == $past(mpp_q)) && (mpp_q == 2'd0) && !mpv_q);
endmodule

bind trap_status_recorder trap_rec_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .trap_vld  (trap_vld),
  .trap_to_m (trap_to_m),
  .cur_priv  (cur_priv),
  .cur_virt  (cur_virt),
  .mem_fault (mem_fault),
  .hv_access (hv_access),
  .ret_vld   (ret_vld),
  .ret_to_m  (ret_to_m),
  .mpp_q     (mpp_q),
  .mpv_q     (mpv_q),
  .spp_q     (spp_q),
  .spv_q     (spv_q),
  .spvp_q    (spvp_q),
  .gva_q     (gva_q),
  .mode_priv (mode_priv),
  .mode_virt (mode_virt)
);

// File: tb/trap_status_recorder_test.sv
module trap_status_recorder_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       trap_vld, trap_to_m, cur_virt, mem_fault, hv_access, mprv_access;
  logic       ret_vld, ret_to_m;
  logic [1:0] cur_priv;
  logic [1:0] mpp_q, mode_priv;
  logic       mpv_q, spp_q, spv_q, spvp_q, gva_q, mode_virt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  trap_status_recorder uut (
    .clk(clk), .rst_n(rst_n), .trap_vld(trap_vld), .trap_to_m(trap_to_m),
    .cur_priv(cur_priv), .cur_virt(cur_virt), .mem_fault(mem_fault),
    .hv_access(hv_access), .mprv_access(mprv_access), .ret_vld(ret_vld),
    .ret_to_m(ret_to_m), .mpp_q(mpp_q), .mpv_q(mpv_q), .spp_q(spp_q),
    .spv_q(spv_q), .spvp_q(spvp_q), .gva_q(gva_q), .mode_priv(mode_priv),
    .mode_virt(mode_virt)
  );

  // stimulus {priv[1:0], virt, to_m, mem, hv, mprv} ,
  // expected {mpp[1:0], mpv, spp, spv, spvp, gva, mode_priv[1:0], mode_virt}
  localparam logic [16:0] VECS [8] = '{
    {7'b01_1_0_1_0_0, 10'b00_0_1_1_1_1_01_0}, // VS page fault to HS
    {7'b00_0_0_1_1_0, 10'b00_0_0_0_1_1_01_0}, // U guest load fault: spv 0, gva 1
    {7'b00_1_0_0_0_0, 10'b00_0_0_1_0_0_01_0}, // VU non-fault to HS
    {7'b01_0_0_1_0_0, 10'b00_0_1_0_0_0_01_0}, // HS ordinary fault
    {7'b11_0_1_1_0_1, 10'b11_0_1_0_0_0_11_0}, // M under mprv, mpv=0
    {7'b00_1_1_1_0_0, 10'b00_1_1_0_0_1_11_0}, // VU fault to M
    {7'b11_0_1_1_0_1, 10'b11_0_1_0_0_1_11_0}, // M under mprv, mpv=1
    {7'b01_0_0_0_1_0, 10'b11_0_1_0_0_0_01_0}  // non-fault with hv flag
  };

  function automatic logic [9:0] state_now();
    return {mpp_q, mpv_q, spp_q, spv_q, spvp_q, gva_q, mode_priv, mode_virt};
  endfunction

  task automatic check(input string req, input logic [9:0] exp);
    checks++;
    if (state_now() !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, state_now(), exp);
    end
  endtask

  task automatic idle_inputs();
    trap_vld = 0; trap_to_m = 0; cur_priv = 2'd0; cur_virt = 0;
    mem_fault = 0; hv_access = 0; mprv_access = 0; ret_vld = 0; ret_to_m = 0;
  endtask

  task automatic trap(input logic [6:0] s);
    @(negedge clk);
    {cur_priv, cur_virt, trap_to_m, mem_fault, hv_access, mprv_access} = s;
    trap_vld = 1;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic ret(input logic to_m);
    @(negedge clk);
    ret_vld = 1; ret_to_m = to_m;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 during reset", 10'b00_0_0_0_0_0_11_0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", 10'b00_0_0_0_0_0_11_0);

    for (int i = 0; i < 8; i++) begin
      trap(VECS[i][16:10]);
      check($sformatf("R2/R3/R4/R5 vector %0d", i), VECS[i][9:0]);
    end

    // R6: garbage on qualifiers without strobes
    @(negedge clk);
    cur_priv = 2'd1; cur_virt = 1; mem_fault = 1; hv_access = 1; mprv_access = 1;
    repeat (3) @(negedge clk);
    check("R6 idle hold", 10'b11_0_1_0_0_0_01_0);
    idle_inputs();

    // R7: trap from VS, then supervisor return resumes VS
    trap(7'b01_1_0_0_0_0);
    check("R3 VS trap", 10'b11_0_1_1_1_0_01_0);
    ret(1'b0);
    check("R7 sret to VS", 10'b11_0_0_0_1_0_01_1);

    // R8: machine return with mpp=M, then from VU
    ret(1'b1);
    check("R8 mret to M", 10'b00_0_0_0_1_0_11_0);
    trap(7'b00_1_1_0_0_0);
    check("R4 VU trap to M", 10'b00_1_0_0_1_0_11_0);
    ret(1'b1);
    check("R8 mret to VU", 10'b00_0_0_0_1_0_00_1);

    // R9: trap and return together
    @(negedge clk);
    cur_priv = 2'd0; cur_virt = 0; trap_vld = 1; trap_to_m = 0;
    ret_vld = 1; ret_to_m = 0;
    @(negedge clk);
    idle_inputs();
    check("R9 trap wins", 10'b00_0_0_0_1_0_01_0);

    // R1: reset in the middle of operation
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 mid reset", 10'b00_0_0_0_0_0_11_0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule